// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block sits between a CPU data-memory request port and an external parallel SRAM. The SRAM hangs off a narrow multiplexed bus: an 8-bit shared address/data port, a separately driven high-address byte, an address-latch strobe that lets an external transparent latch capture the low address byte, and active-low read and write strobes. Requests below the internal-memory ceiling are left to on-chip memory and produce no bus activity. Requests at or above it start one external bus cycle.

Each bus cycle stretches its strobe by a wait-state code. There are two such codes, one for a lower and one for an upper address sector, and a 3-bit limit value sets where the sectors split. An optional bus keeper holds the last value seen on the shared lines while the bus is idle. When the slowest wait setting is in use, an extra latch-strobe pulse is placed in the last period of the cycle if the CPU reports that its next operation also touches RAM.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is enabled and idle, so a request held with `req_valid` waits, with its fields kept stable, until it is taken. The response side carries no back-pressure: `rsp_valid` is a one-cycle pulse per external access and the CPU must take it in that cycle.

Top module: `xmb_bus_ctrl`

## Requirements
- R1: A taken request with an address below 0x2200 starts no bus cycle. `bus_ale` stays low, both strobes stay high, no `rsp_valid` pulse follows, and `req_ready` stays high.
- R2: An external access lasts 4 + min(w,2) + (w==3 ? 1 : 0) cycles from the cycle after acceptance up to and including the `rsp_valid` cycle, where w is the selected 2-bit wait code. Code 3 gives 7 cycles.
- R3: The active strobe (`bus_rd_n` or `bus_wr_n`) is low for 1 + min(w,2) consecutive cycles in each access.
- R4: The upper-sector code `wait_hi` applies when `sector_lim` is nonzero and the address is at least `sector_lim` × 0x2000. Otherwise `wait_lo` applies, so a zero limit puts the whole external range in the lower sector.
- R5: In the first cycle after acceptance, `bus_ale` is high for one cycle, `bus_hi` carries address bits 15:8, and `bus_ad` carries address bits 7:0.
- R6: In a read, `bus_ad` is released from the cycle after the address phase. The value on `bus_ad` in the last low-strobe cycle is returned on `rsp_rdata` together with `rsp_valid`.
- R7: In a write, the controller drives the write data on `bus_ad` from the cycle after the address phase, through all `bus_wr_n` low cycles, and for one cycle after `bus_wr_n` rises.
- R8: `bus_rd_n` and `bus_wr_n` are never low together, and both are high in the cycle before the controller starts or stops driving `bus_ad`.
- R9: With `keep_en` high and the controller idle and enabled, `bus_ad` is driven with the last value placed on it: the last address byte, write data, or captured read data.
- R10: With wait code 3, `bus_ale` is also high in the 7th (final) cycle when `next_is_ram` is high in that cycle, and stays low there otherwise. With other codes there is no trailing pulse.
- R11: With `xif_en` low, `bus_ale` is low, both strobes are high, `bus_ad` and `bus_hi` are released, and `req_ready` is low.
- R12: `req_ready` is high only when enabled and idle. `rsp_valid` pulses once, for one cycle, per external access and never while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xif_en | input | 1 | Enables the external interface |
| keep_en | input | 1 | Enables the idle bus keeper |
| sector_lim | input | 3 | Sector split point in units of 0x2000, 0 = all lower |
| wait_lo | input | 2 | Wait code for the lower sector |
| wait_hi | input | 2 | Wait code for the upper sector |
| next_is_ram | input | 1 | CPU hint: next operation accesses RAM |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 16 | Data-space address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse for an external access |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid |
| bus_hi | output | 8 | High address byte, released when disabled |
| bus_ad | inout | 8 | Multiplexed low address / data lines |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench builds the controller with its default parameters: a 16-bit address, an 8-bit bus, the 0x2200 internal ceiling, a 3-bit sector limit and the keeper hardware present. With these values the bench can reach every wait code in both sectors, the exact sector boundary at 0x6000 under limit 3, the zero-limit case and both sides of the internal ceiling. Because the keeper is present, its hold-after-write and hold-after-read behaviour can also be observed directly on the shared lines.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  localparam int WS_W  = 2;
  localparam int CNT_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TURN,
    ST_STRB,
    ST_HOLD,
    ST_TAIL
  } xmb_state_e;

  // extra strobe cycles beyond the first, per wait code
  function automatic logic [CNT_W-1:0] strobe_extra(input logic [WS_W-1:0] ws);
    logic [CNT_W-1:0] r;
    case (ws)
      2'd0:    r = 2'd0;
      2'd1:    r = 2'd1;
      default: r = 2'd2;
    endcase
    return r;
  endfunction

  function automatic logic has_tail(input logic [WS_W-1:0] ws);
    return ws == 2'd3;
  endfunction
endpackage

// File: rtl/xmb_decode.sv
module xmb_decode
  import xmb_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              LIM_W   = 3,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h2200
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LIM_W-1:0]  lim,
  input  logic [WS_W-1:0]   ws_lo,
  input  logic [WS_W-1:0]   ws_hi,
  output logic              is_ext,
  output logic [WS_W-1:0]   ws_sel
);
  localparam int SEC_SHIFT = ADDR_W - LIM_W;

  logic [ADDR_W-1:0] boundary;
  logic              in_upper;

  always_comb begin
    boundary = {lim, {SEC_SHIFT{1'b0}}};
    is_ext   = addr >= INT_TOP;
    in_upper = (lim != '0) && (addr >= boundary);
    ws_sel   = in_upper ? ws_hi : ws_lo;
  end
endmodule

// File: rtl/xmb_seq.sv
module xmb_seq
  import xmb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start,
  input  logic            we_in,
  input  logic [WS_W-1:0] ws_in,
  input  logic            next_is_ram,
  output logic            idle,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            oe_addr,
  output logic            oe_data,
  output logic            capture,
  output logic            done
);
  xmb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             we_q;
  logic [WS_W-1:0]  ws_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_TURN;
      ST_TURN: begin
        state_d = ST_STRB;
        cnt_d   = strobe_extra(ws_q);
      end
      ST_STRB: begin
        if (cnt_q == '0) state_d = ST_HOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_HOLD: state_d = has_tail(ws_q) ? ST_TAIL : ST_IDLE;
      ST_TAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (!en) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      ws_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == ST_IDLE && start) begin
        we_q <= we_in;
        ws_q <= ws_in;
      end
    end
  end

  always_comb begin
    idle    = state_q == ST_IDLE;
    ale     = en && ((state_q == ST_ADDR) || (state_q == ST_TAIL && next_is_ram));
    rd_n    = !(en && state_q == ST_STRB && !we_q);
    wr_n    = !(en && state_q == ST_STRB && we_q);
    oe_addr = en && state_q == ST_ADDR;
    oe_data = en && we_q &&
              (state_q == ST_TURN || state_q == ST_STRB || state_q == ST_HOLD);
    capture = en && !we_q && state_q == ST_STRB && cnt_q == '0;
    done    = en && ((state_q == ST_HOLD && !has_tail(ws_q)) || state_q == ST_TAIL);
  end
endmodule

// File: rtl/xmb_pads.sv
module xmb_pads #(
  parameter int DATA_W     = 8,
  parameter bit HAS_KEEPER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              keep_en,
  input  logic              idle,
  input  logic              oe_addr,
  input  logic              oe_data,
  input  logic              capture,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] last_q;
  logic              keep_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (capture) rdata <= ad_in;
  end

  generate
    if (HAS_KEEPER) begin : g_keeper
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        last_q <= '0;
        else if (oe_addr)  last_q <= addr_lo;
        else if (oe_data)  last_q <= wdata;
        else if (capture)  last_q <= ad_in;
      end
      assign keep_drive = en && keep_en && idle;
    end else begin : g_no_keeper
      assign last_q     = '0;
      assign keep_drive = 1'b0;
    end
  endgenerate

  always_comb begin
    ad_oe  = oe_addr || oe_data || keep_drive;
    ad_out = oe_addr ? addr_lo : (oe_data ? wdata : last_q);
  end
endmodule

// File: rtl/xmb_bus_ctrl.sv
module xmb_bus_ctrl
  import xmb_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                LIM_W      = 3,
  parameter logic [ADDR_W-1:0] INT_TOP    = 16'h2200,
  parameter bit                HAS_KEEPER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xif_en,
  input  logic              keep_en,
  input  logic [LIM_W-1:0]  sector_lim,
  input  logic [WS_W-1:0]   wait_lo,
  input  logic [WS_W-1:0]   wait_hi,
  input  logic              next_is_ram,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output wire  [ADDR_W-DATA_W-1:0] bus_hi,
  inout  wire  [DATA_W-1:0] bus_ad,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              is_ext;
  logic [WS_W-1:0]   ws_sel;
  logic              idle, start;
  logic              oe_addr, oe_data, capture, done;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] da_out;
  logic              da_oe;

  xmb_decode #(
    .ADDR_W (ADDR_W),
    .LIM_W  (LIM_W),
    .INT_TOP(INT_TOP)
  ) u_decode (
    .addr  (req_addr),
    .lim   (sector_lim),
    .ws_lo (wait_lo),
    .ws_hi (wait_hi),
    .is_ext(is_ext),
    .ws_sel(ws_sel)
  );

  assign req_ready = xif_en && idle;
  assign start     = req_valid && req_ready && is_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  xmb_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (xif_en),
    .start      (start),
    .we_in      (req_we),
    .ws_in      (ws_sel),
    .next_is_ram(next_is_ram),
    .idle       (idle),
    .ale        (bus_ale),
    .rd_n       (bus_rd_n),
    .wr_n       (bus_wr_n),
    .oe_addr    (oe_addr),
    .oe_data    (oe_data),
    .capture    (capture),
    .done       (done)
  );

  xmb_pads #(
    .DATA_W    (DATA_W),
    .HAS_KEEPER(HAS_KEEPER)
  ) u_pads (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (xif_en),
    .keep_en(keep_en),
    .idle   (idle),
    .oe_addr(oe_addr),
    .oe_data(oe_data),
    .capture(capture),
    .addr_lo(addr_q[DATA_W-1:0]),
    .wdata  (wdata_q),
    .ad_in  (bus_ad),
    .ad_out (da_out),
    .ad_oe  (da_oe),
    .rdata  (rsp_rdata)
  );

  assign rsp_valid = done;
  assign bus_ad    = da_oe ? da_out : {DATA_W{1'bz}};
  assign bus_hi    = xif_en ? addr_q[ADDR_W-1:DATA_W] : {HI_W{1'bz}};
endmodule

// File: rtl/xmb_checker.sv
module xmb_checker #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h2200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              da_oe
);
  assert_internal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr < INT_TOP) |=> (!ale && rd_n && wr_n && !rsp_valid));

  assert_addr_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr >= INT_TOP) |=> (ale || !en));

  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !da_oe);

  assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> da_oe);

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_turn_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (da_oe != $past(da_oe)) |-> $past(rd_n && wr_n));

  assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (rd_n && wr_n && !ale && !da_oe && !req_ready));

  assert_rsp_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_rsp_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind xmb_bus_ctrl xmb_checker #(
  .ADDR_W (ADDR_W),
  .INT_TOP(INT_TOP)
) u_xmb_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (xif_en),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .ale      (bus_ale),
  .rd_n     (bus_rd_n),
  .wr_n     (bus_wr_n),
  .da_oe    (da_oe)
);

// File: tb/xmb_bus_ctrl_bench.sv
module xmb_bus_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xif_en = 1'b0;
  logic        keep_en = 1'b0;
  logic [2:0]  sector_lim = '0;
  logic [1:0]  wait_lo = '0;
  logic [1:0]  wait_hi = '0;
  logic        next_is_ram = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  wire  [7:0]  bus_hi;
  wire  [7:0]  bus_ad;
  logic        bus_ale, bus_rd_n, bus_wr_n;

  // external latch + memory model
  logic [7:0] mem [0:1023];
  logic [7:0] lo_lat = '0;
  logic       drv_oe = 1'b0;
  logic [7:0] drv_val = '0;
  logic [9:0] mem_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 1'b0;

  assign mem_idx = {bus_hi[1:0], lo_lat};
  assign bus_ad  = !bus_rd_n ? mem[mem_idx] : (drv_oe ? drv_val : 8'bz);

  always @(posedge clk) begin
    if (bus_ale) lo_lat <= bus_ad;
    if (!bus_wr_n) mem[mem_idx] <= bus_ad;
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  xmb_bus_ctrl u_xmb_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .xif_en(xif_en), .keep_en(keep_en),
    .sector_lim(sector_lim), .wait_lo(wait_lo), .wait_hi(wait_hi),
    .next_is_ram(next_is_ram), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_hi(bus_hi),
    .bus_ad(bus_ad), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 7) + (i >> 8));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // one request; counts cycles from the address phase to the response
  task automatic access(input logic [15:0] a, input bit we, input logic [7:0] wd,
                        output int cyc, output int strb, output int ales,
                        output logic [7:0] rd, output logic [7:0] hi_at_ale,
                        output logic [7:0] lo_at_ale, output bit both_low);
    cyc = 0; strb = 0; ales = 0; rd = '0; both_low = 1'b0;
    hi_at_ale = '0; lo_at_ale = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      cyc++;
      if (!bus_rd_n || !bus_wr_n) strb++;
      if (!bus_rd_n && !bus_wr_n) both_low = 1'b1;
      if (bus_ale) begin
        if (ales == 0) begin
          hi_at_ale = bus_hi;
          lo_at_ale = bus_ad;
        end
        ales++;
      end
      if (rsp_valid) begin
        rd = rsp_rdata;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(bus_rd_n && bus_wr_n && !bus_ale, "R11 strobes idle in reset/disabled",
          {bus_rd_n, bus_wr_n, bus_ale}, 3'b110);
    check(!req_ready, "R11 ready low while disabled", req_ready, 0);
    xif_en = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R12 ready high when idle", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_wait_sweep;
    int c, s, al; logic [7:0] rd, hi, lo; bit bl;
    sector_lim = '0;
    for (int w = 0; w < 4; w++) begin
      wait_lo = 2'(w);
      access(16'h2340 + 16'(w), 1'b1, 8'hC0 + 8'(w), c, s, al, rd, hi, lo, bl);
      check(c == 4 + (w > 2 ? 2 : w) + (w == 3 ? 1 : 0), "R2 write cycle length", c,
            4 + (w > 2 ? 2 : w) + (w == 3 ? 1 : 0));
      check(s == 1 + (w > 2 ? 2 : w), "R3 write strobe width", s, 1 + (w > 2 ? 2 : w));
      check(hi == 8'h23 && lo == 8'h40 + 8'(w), "R5 address phase bytes", {hi, lo},
            {8'h23, 8'h40 + 8'(w)});
      check(!bl, "R8 strobes never both low", bl, 0);
      access(16'h2340 + 16'(w), 1'b0, 8'h00, c, s, al, rd, hi, lo, bl);
      check(rd == 8'hC0 + 8'(w), "R6 R7 read back written value", rd, 8'hC0 + 8'(w));
      check(s == 1 + (w > 2 ? 2 : w), "R3 read strobe width", s, 1 + (w > 2 ? 2 : w));
    end
    access(16'hA1FF, 1'b0, 8'h00, c, s, al, rd, hi, lo, bl);
    check(rd == init_val(10'h1FF), "R6 read of untouched location", rd, init_val(10'h1FF));
  endtask

  task automatic t_sector;
    int c, s, al; logic [7:0] rd, hi, lo; bit bl;
    wait_lo = 2'd0; wait_hi = 2'd3; sector_lim = 3'd3;
    access(16'h5FFF, 1'b0, 8'h00, c, s, al, rd, hi, lo, bl);
    check(c == 4, "R4 below boundary uses lower code", c, 4);
    access(16'h6000, 1'b0, 8'h00, c, s, al, rd, hi, lo, bl);
    check(c == 7, "R4 at boundary uses upper code", c, 7);
    sector_lim = 3'd0;
    access(16'hE000, 1'b0, 8'h00, c, s, al, rd, hi, lo, bl);
    check(c == 4, "R4 zero limit is all lower", c, 4);
  endtask

  task automatic t_internal;
    bit saw_bus = 1'b0, saw_rsp = 1'b0, lost_ready = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h21FF; req_we = 1'b1; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (bus_ale || !bus_rd_n || !bus_wr_n) saw_bus = 1'b1;
      if (rsp_valid) saw_rsp = 1'b1;
      if (!req_ready) lost_ready = 1'b1;
      @(negedge clk);
    end
    check(!saw_bus, "R1 internal address makes no bus cycle", saw_bus, 0);
    check(!saw_rsp && !lost_ready, "R1 internal address no response, ready kept",
          {saw_rsp, lost_ready}, 0);
  endtask

  task automatic t_trailing;
    int c, s, al; logic [7:0] rd, hi, lo; bit bl;
    sector_lim = '0;
    wait_lo = 2'd3; next_is_ram = 1'b1;
    access(16'h3000, 1'b0, 8'h00, c, s, al, rd, hi, lo, bl);
    check(al == 2, "R10 trailing pulse when next is RAM", al, 2);
    next_is_ram = 1'b0;
    access(16'h3000, 1'b0, 8'h00, c, s, al, rd, hi, lo, bl);
    check(al == 1, "R10 no trailing pulse otherwise", al, 1);
    wait_lo = 2'd0; next_is_ram = 1'b1;
    access(16'h3000, 1'b0, 8'h00, c, s, al, rd, hi, lo, bl);
    check(al == 1, "R10 no trailing pulse below code 3", al, 1);
    next_is_ram = 1'b0;
  endtask

  task automatic t_keeper;
    int c, s, al; logic [7:0] rd, hi, lo; bit bl;
    keep_en = 1'b1; wait_lo = 2'd1;
    access(16'h2500, 1'b1, 8'h3C, c, s, al, rd, hi, lo, bl);
    @(negedge clk); @(negedge clk);
    check(bus_ad == 8'h3C, "R9 keeper holds write data", bus_ad, 8'h3C);
    access(16'h2601, 1'b0, 8'h00, c, s, al, rd, hi, lo, bl);
    @(negedge clk); @(negedge clk);
    check(bus_ad == init_val(10'h201), "R9 keeper holds read data", bus_ad,
          init_val(10'h201));
    keep_en = 1'b0;
  endtask

  task automatic t_disable;
    bit saw_bus = 1'b0;
    @(negedge clk);
    xif_en = 1'b0;
    drv_oe = 1'b1; drv_val = 8'h5A;
    req_valid = 1'b1; req_addr = 16'h4000; req_we = 1'b1;
    @(negedge clk);
    check(bus_ad == 8'h5A, "R11 shared lines released when disabled", bus_ad, 8'h5A);
    check(!req_ready, "R11 R12 ready low when disabled", req_ready, 0);
    for (int k = 0; k < 6; k++) begin
      if (bus_ale || !bus_rd_n || !bus_wr_n) saw_bus = 1'b1;
      @(negedge clk);
    end
    check(!saw_bus, "R11 no strobes when disabled", saw_bus, 0);
    req_valid = 1'b0; drv_oe = 1'b0;
    xif_en = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wait_sweep();
    t_sector();
    t_internal();
    t_trailing();
    t_keeper();
    t_disable();
    if (!done_flag) begin
      done_flag = 1'b1;
      report();
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected fewer cycles", WATCHDOG);
      report();
      $finish;
    end
  end
endmodule